// File: doc/BRIEF.md
# Daisy-Chained Interrupt Acknowledge Chain

This block resolves which of several interrupt sources answers a processor's interrupt acknowledge. It is a row of identical agent cells, each holding a pending flag and a programmable vector register. A grant signal enters the first cell tied active and ripples from cell to cell. A cell with nothing pending passes the grant on. A cell with a pending request keeps it and blocks every cell after it. Priority is therefore purely positional: agent 0 is highest.

The processor sees a single interrupt line, which is the OR of all pending flags. To acknowledge, it raises `ack_req_i`. The winning agent's vector is then offered on a valid/ready stream (`vec_valid_o`, `vec_data_o`, `vec_ready_i`).

Back-pressure rules for that stream are as follows. While the vector is offered and not taken, the vector and the grant stay frozen. The transfer happens on the clock edge where valid and ready are both high. On that edge the winner drops its pending flag. If other requests remain pending, the next winner is offered in the following cycle.

Top module: `irq_chain_top`

## Requirements
- R1: After reset no agent is pending, `irq_o` and `vec_valid_o` are low, `vec_data_o` is zero, and the vector register of agent i holds the value i.
- R2: `irq_o` is high exactly when at least one agent has a pending request.
- R3: The winner is the lowest-indexed pending agent. `grant_o` bit i is high only for that agent, and only while `ack_req_i` is high, so `grant_o` has at most one bit set.
- R4: `vec_valid_o` equals `ack_req_i` AND (any agent pending). While it is high, `vec_data_o` is the vector register of the winner.
- R5: On an edge where `vec_valid_o` and `vec_ready_i` are both high, the winner clears its pending flag and every other agent keeps its flag.
- R6: While `vec_valid_o` is high and `vec_ready_i` is low, the next cycle still has `vec_valid_o` high with unchanged `vec_data_o` and `grant_o`.
- R7: A pulse on `req_i[i]` while `ack_req_i` is low sets agent i pending at that edge. A pulse while `ack_req_i` is high is held aside. It becomes pending on the first edge at which `ack_req_i` is low. A request to an agent already pending changes nothing.
- R8: When `vec_we_i` is high and `ack_req_i` is low, agent `vec_wsel_i` loads `vec_wdata_i` at the edge. The write is ignored when `ack_req_i` is high, and also when `vec_wsel_i` is not below the agent count.
- R9: With `ack_req_i` low, or with nothing pending, `vec_valid_o` is low and `vec_data_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | N_AGENTS | Per-agent request pulses, bit 0 highest priority |
| vec_we_i | input | 1 | Vector register write strobe |
| vec_wsel_i | input | IDX_W | Index of the agent whose vector is written |
| vec_wdata_i | input | VEC_W | Vector value to write |
| irq_o | output | 1 | Interrupt line to the processor, OR of pending flags |
| ack_req_i | input | 1 | Acknowledge cycle open |
| vec_valid_o | output | 1 | Winner's vector offered |
| vec_ready_i | input | 1 | Processor takes the vector |
| vec_data_o | output | VEC_W | Winner's vector, zero when not valid |
| grant_o | output | N_AGENTS | One-hot grant of the winning agent during acknowledge |

## Verification
The stability property assumes that the processor keeps `ack_req_i` high while it holds `vec_ready_i` low on an offered vector. The stimulus therefore never drops `ack_req_i` in the cycle after a stall. The properties on late requests and frozen vectors assume that request and write pulses are clean single-cycle levels at the edge. The stimulus drives all inputs at the falling edge, and random stall cycles always carry `ack_req_i` high. Random phases mix sparse request bursts, writes that include out-of-range selects, and stalls. Directed phases cover full-chain contention, requests arriving mid-acknowledge, and an acknowledge with nothing pending.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

  // Width of an index able to address n agents (at least one bit).
  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/irq_agent.sv
module irq_agent #(
  parameter int unsigned VEC_W   = 8,
  parameter logic [VEC_W-1:0] RST_VEC = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic             hold_i,
  input  logic             fire_i,
  input  logic             pri_in_i,
  output logic             pri_out_o,
  output logic             win_o,
  output logic             pend_o,
  input  logic             vec_we_i,
  input  logic [VEC_W-1:0] vec_wdata_i,
  output logic [VEC_W-1:0] vec_o
);

  logic             pend_q, late_q;
  logic             pend_d, late_d;
  logic [VEC_W-1:0] vec_q;

  // grant passes on only when this agent has nothing pending
  assign win_o     = pri_in_i & pend_q;
  assign pri_out_o = pri_in_i & ~pend_q;
  assign pend_o    = pend_q;
  assign vec_o     = vec_q;

  always_comb begin
    pend_d = pend_q & ~(fire_i & win_o);
    late_d = late_q;
    if (hold_i) begin
      late_d = late_q | set_i;
    end else begin
      pend_d = pend_d | set_i | late_q;
      late_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      late_q <= 1'b0;
      vec_q  <= RST_VEC;
    end else begin
      pend_q <= pend_d;
      late_q <= late_d;
      if (vec_we_i && !hold_i) vec_q <= vec_wdata_i;
    end
  end

  // R5
  winner_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i && win_o |=> !pend_o);

  // R7
  late_join_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_i && set_i |=> pend_o);

  // R8
  vec_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> vec_o == $past(vec_o));

endmodule

// File: rtl/irq_vec_merge.sv
module irq_vec_merge #(
  parameter int unsigned N_AGENTS = 5,
  parameter int unsigned VEC_W    = 8
) (
  input  logic [N_AGENTS-1:0]       win_i,
  input  logic [N_AGENTS*VEC_W-1:0] vec_flat_i,
  input  logic                      en_i,
  output logic [VEC_W-1:0]          bus_o
);

  logic [VEC_W-1:0] part [N_AGENTS+1];

  assign part[0] = '0;

  generate
    for (genvar i = 0; i < N_AGENTS; i++) begin : g_or
      assign part[i+1] = part[i] |
        ((win_i[i] && en_i) ? vec_flat_i[i*VEC_W +: VEC_W] : '0);
    end
  endgenerate

  assign bus_o = part[N_AGENTS];

endmodule

// File: rtl/irq_chain_top.sv
module irq_chain_top
  import irq_chain_pkg::*;
#(
  parameter int unsigned N_AGENTS = 5,
  parameter int unsigned VEC_W    = 8,
  localparam int unsigned IDX_W   = idx_width(N_AGENTS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_AGENTS-1:0] req_i,
  input  logic                vec_we_i,
  input  logic [IDX_W-1:0]    vec_wsel_i,
  input  logic [VEC_W-1:0]    vec_wdata_i,
  output logic                irq_o,
  input  logic                ack_req_i,
  output logic                vec_valid_o,
  input  logic                vec_ready_i,
  output logic [VEC_W-1:0]    vec_data_o,
  output logic [N_AGENTS-1:0] grant_o
);

  logic [N_AGENTS:0]         pri;
  logic [N_AGENTS-1:0]       win, pend;
  logic [N_AGENTS*VEC_W-1:0] vec_flat;
  logic                      fire;

  // the head of the chain always sees no higher-priority claimant
  assign pri[0] = 1'b1;

  generate
    for (genvar i = 0; i < N_AGENTS; i++) begin : g_agent
      logic we_sel;
      assign we_sel = vec_we_i && (vec_wsel_i == IDX_W'(i));
      irq_agent #(
        .VEC_W   (VEC_W),
        .RST_VEC (VEC_W'(i))
      ) u_agent (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_i       (req_i[i]),
        .hold_i      (ack_req_i),
        .fire_i      (fire),
        .pri_in_i    (pri[i]),
        .pri_out_o   (pri[i+1]),
        .win_o       (win[i]),
        .pend_o      (pend[i]),
        .vec_we_i    (we_sel),
        .vec_wdata_i (vec_wdata_i),
        .vec_o       (vec_flat[i*VEC_W +: VEC_W])
      );
    end
  endgenerate

  irq_vec_merge #(
    .N_AGENTS (N_AGENTS),
    .VEC_W    (VEC_W)
  ) u_merge (
    .win_i      (win),
    .vec_flat_i (vec_flat),
    .en_i       (ack_req_i),
    .bus_o      (vec_data_o)
  );

  assign irq_o       = |pend;
  assign vec_valid_o = ack_req_i & ~pri[N_AGENTS];
  assign fire        = vec_valid_o & vec_ready_i;
  assign grant_o     = win & {N_AGENTS{ack_req_i}};

  // R3
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  // R6
  stall_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o && !vec_ready_i && ack_req_i |=>
      vec_valid_o && $stable(vec_data_o) && $stable(grant_o));

  // R9
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_req_i |-> !vec_valid_o && vec_data_o == '0);

  // R2
  irq_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> irq_o);

endmodule

// File: tb/irq_chain_top_test.sv
module irq_chain_top_test;
  localparam int N  = 5;
  localparam int W  = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  req;
  logic          we;
  logic [IW-1:0] wsel;
  logic [W-1:0]  wdata;
  logic          irq;
  logic          ack;
  logic          vvalid;
  logic          vready;
  logic [W-1:0]  vdata;
  logic [N-1:0]  grant;

  always #2.5 clk = ~clk;

  irq_chain_top #(.N_AGENTS(N), .VEC_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .vec_we_i(we), .vec_wsel_i(wsel),
    .vec_wdata_i(wdata), .irq_o(irq), .ack_req_i(ack), .vec_valid_o(vvalid),
    .vec_ready_i(vready), .vec_data_o(vdata), .grant_o(grant)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [N-1:0] m_pend, m_late;
  logic [W-1:0] m_vec [N];

  task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic int first_pending();
    for (int i = 0; i < N; i++) if (m_pend[i]) return i;
    return -1;
  endfunction

  // One cycle: drive at the falling edge, check combinational outputs, advance model.
  task automatic step(input logic [N-1:0] r, input logic w, input logic [IW-1:0] ws,
                      input logic [W-1:0] wd, input logic a, input logic rd, input string tag);
    int           wi;
    logic         e_valid;
    logic [W-1:0] e_data;
    logic [N-1:0] e_grant;
    @(negedge clk);
    req = r; we = w; wsel = ws; wdata = wd; ack = a; vready = rd;
    #1;
    wi      = first_pending();
    e_valid = a && (wi >= 0);
    e_data  = e_valid ? m_vec[wi] : '0;
    e_grant = e_valid ? (N'(1) << wi) : '0;
    cmp($sformatf("%s R2 irq", tag), 32'(irq), 32'(m_pend != '0));
    cmp($sformatf("%s R3 grant", tag), 32'(grant), 32'(e_grant));
    cmp($sformatf("%s R4 valid", tag), 32'(vvalid), 32'(e_valid));
    cmp($sformatf("%s R4 data", tag), 32'(vdata), 32'(e_data));
    if (e_valid && rd) m_pend[wi] = 1'b0;
    if (a) begin
      m_late = m_late | r;
    end else begin
      m_pend = m_pend | r | m_late;
      m_late = '0;
      if (w && (int'(ws) < N)) m_vec[ws] = wd;
    end
  endtask

  task automatic idle(input int n, input logic a, input string tag);
    for (int k = 0; k < n; k++) step('0, 1'b0, '0, '0, a, 1'b1, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; req = '0; we = 1'b0; wsel = '0; wdata = '0; ack = 1'b0; vready = 1'b0;
    m_pend = '0; m_late = '0;
    for (int i = 0; i < N; i++) m_vec[i] = W'(i);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, then read reset vectors in priority order
    #1;
    cmp("R1 irq after reset", 32'(irq), 32'd0);
    cmp("R1 valid after reset", 32'(vvalid), 32'd0);
    cmp("R1 data after reset", 32'(vdata), 32'd0);
    step('1, 1'b0, '0, '0, 1'b0, 1'b0, "R1");
    for (int k = 0; k < N; k++) step('0, 1'b0, '0, '0, 1'b1, 1'b1, "R1 R5 drain");
    idle(2, 1'b1, "R9 empty ack");

    // R3/R6/R5: contention between agents 3 and 1 with a stall
    step(5'b01010, 1'b0, '0, '0, 1'b0, 1'b0, "R3 contend");
    for (int k = 0; k < 3; k++) step('0, 1'b0, '0, '0, 1'b1, 1'b0, "R6 stall");
    step('0, 1'b0, '0, '0, 1'b1, 1'b1, "R5 take1");
    step('0, 1'b0, '0, '0, 1'b1, 1'b0, "R6 stall2");
    step('0, 1'b0, '0, '0, 1'b1, 1'b1, "R5 take3");
    idle(1, 1'b0, "R9 idle");

    // R7: agent 0 asks while agent 2 is being acknowledged
    step(5'b00100, 1'b0, '0, '0, 1'b0, 1'b0, "R7 setup");
    step(5'b00001, 1'b0, '0, '0, 1'b1, 1'b0, "R7 late");
    step('0, 1'b0, '0, '0, 1'b1, 1'b0, "R7 held");
    step('0, 1'b0, '0, '0, 1'b1, 1'b1, "R7 take2");
    step('0, 1'b0, '0, '0, 1'b0, 1'b0, "R7 merge");
    step('0, 1'b0, '0, '0, 1'b1, 1'b1, "R7 take0");
    step(5'b00010, 1'b0, '0, '0, 1'b0, 1'b0, "R7 dup a");
    step(5'b00010, 1'b0, '0, '0, 1'b0, 1'b0, "R7 dup b");
    step('0, 1'b0, '0, '0, 1'b1, 1'b1, "R7 dup take");
    idle(1, 1'b1, "R7 dup empty");

    // R8: write ignored during ack, out-of-range ignored, normal write taken
    step('0, 1'b1, 3'd4, 8'hAA, 1'b1, 1'b0, "R8 wr in ack");
    step('0, 1'b1, 3'd6, 8'h55, 1'b0, 1'b0, "R8 wr range");
    step(5'b10000, 1'b0, '0, '0, 1'b0, 1'b0, "R8 req4");
    step('0, 1'b0, '0, '0, 1'b1, 1'b1, "R8 read4 old");
    step('0, 1'b1, 3'd4, 8'h3C, 1'b0, 1'b0, "R8 wr ok");
    step(5'b10000, 1'b0, '0, '0, 1'b0, 1'b0, "R8 req4b");
    step('0, 1'b0, '0, '0, 1'b1, 1'b1, "R8 read4 new");

    // Random phase: stalls always keep ack high (R6 assumption)
    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] r;
      logic a, rd;
      r  = (($urandom % 4) == 0) ? N'($urandom) : '0;
      a  = ($urandom % 3) != 0;
      rd = ($urandom % 2) == 0;
      if (vvalid && !vready) a = 1'b1;
      step(r, ($urandom % 4) == 0, IW'($urandom), W'($urandom), a, rd, "rand");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule